// File: doc/BRIEF.md
# Paged Memory Address Unit

This unit forms the full addresses for the split instruction and data stores of a small 8-bit processor core. Each store is cut into pages of sixteen words. Two page registers hold the upper address bits, one for the instruction side and one for the data side. A page-select command, qualified by a one-bit target selector, loads one of them. Ordinary fetches, loads and stores then carry only a 4-bit offset. The unit joins the current page and that offset into a 7-bit address, so any word of the selected page is reached in a single cycle.

The instruction store holds 128 words of 12 bits and the data store holds 128 bytes. Both are modelled behaviourally inside the unit. Reads are combinational and writes land on the rising clock edge. The instruction store also has a load port so that a program can be placed in it, and this port uses the same page-plus-offset address as a fetch. Pipeline control, decode and the ALU live elsewhere.

Top module: `paged_mem_unit`

## Requirements
- R1: The external reset is asynchronous and active low, and its release is synchronised to the clock. While the unit is in reset, both page registers read as page 0 and page-select commands have no effect.
- R2: The instruction address equals the instruction page times 16 plus the fetch offset. The page forms bits 6..4 and the offset forms bits 3..0.
- R3: The data address equals the data page times 16 plus the data offset. The page forms bits 6..4 and the offset forms bits 3..0.
- R4: A page-select command with target 0 loads the instruction page, and with target 1 it loads the data page. The other page register keeps its value.
- R5: A page-select command takes effect on the clock edge that ends its cycle. An access in the same cycle uses the old page, and the new page applies from the next cycle.
- R6: A data byte is written to the addressed location only on a clock edge at which the data write strobe is high. When the strobe is low, the stored contents do not change.
- R7: While the data read strobe is high, the data output shows the addressed byte combinationally, including the value from before a write in the same cycle. While the strobe is low, the data output is zero.
- R8: While fetch is enabled, the instruction output shows the addressed 12-bit word combinationally. While fetch is disabled, the instruction output is zero.
- R9: When the program-load strobe is high, the 12-bit load word is written to the instruction address on the clock edge.
- R10: The instruction-store enable is high when fetch or program-load is high. The data read and write enables follow their strobes in the same cycle.
- R11: Without a page-select command for it, a page register holds its value whatever the access inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pg_cmd_valid | input | 1 | Page-select command present |
| pg_cmd_space | input | 1 | Command target: 0 instruction page, 1 data page |
| pg_cmd_page | input | 3 | Page number to load |
| ifetch_en | input | 1 | Instruction fetch strobe |
| ifetch_off | input | 4 | In-page instruction offset |
| iload_en | input | 1 | Program-load write strobe |
| iload_word | input | 12 | Word written by program load |
| drd_en | input | 1 | Data read strobe |
| dwr_en | input | 1 | Data write strobe |
| d_off | input | 4 | In-page data offset |
| dwr_byte | input | 8 | Byte to store |
| imem_addr | output | 7 | Full instruction address |
| imem_en | output | 1 | Instruction store enable |
| instr_word | output | 12 | Fetched instruction |
| dmem_addr | output | 7 | Full data address |
| dmem_rd | output | 1 | Data store read enable |
| dmem_wr | output | 1 | Data store write enable |
| drd_byte | output | 8 | Byte read from the data store |

## Verification
The assertions assume that the page-select command and the access strobes are stable at the sampling edge and are driven to known values from the first clock after reset. They also assume that the write-then-read check looks only at a following read of the same offset while no data page command intervenes. The bench drives every input one time unit after the rising edge. It keeps all strobes low until both stores have been filled, so no comparison involves an unwritten location. It exercises page commands both during reset and in the cycles just after release, which the reset-related assertions take into account.

// File: rtl/pmu_pkg.sv
`timescale 1ns/1ps
package pmu_pkg;
  localparam int unsigned INSTR_W = 12;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned OFF_W   = 4;
  localparam int unsigned PAGE_W  = 3;
  localparam int unsigned ADDR_W  = PAGE_W + OFF_W;
  localparam int unsigned N_SPACE = 2;

  typedef enum logic {
    SPACE_INSTR = 1'b0,
    SPACE_DATA  = 1'b1
  } space_e;
endpackage

// File: rtl/pmu_rst_sync.sv
`timescale 1ns/1ps
module pmu_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/pmu_page_reg.sv
`timescale 1ns/1ps
module pmu_page_reg #(
  parameter int unsigned PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [PAGE_W-1:0] page_in,
  output logic [PAGE_W-1:0] page_q
);
  logic [PAGE_W-1:0] page_d;

  always_comb begin
    page_d = page_q;
    if (load) page_d = page_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) page_q <= '0;
    else        page_q <= page_d;
  end
endmodule

// File: rtl/pmu_store.sv
`timescale 1ns/1ps
module pmu_store #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  always_comb begin
    rdata = cells[addr];
  end
endmodule

// File: rtl/paged_mem_unit.sv
`timescale 1ns/1ps
module paged_mem_unit
  import pmu_pkg::*;
#(
  parameter int unsigned P_INSTR_W = INSTR_W,
  parameter int unsigned P_DATA_W  = DATA_W,
  parameter int unsigned P_OFF_W   = OFF_W,
  parameter int unsigned P_PAGE_W  = PAGE_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          pg_cmd_valid,
  input  logic                          pg_cmd_space,
  input  logic [P_PAGE_W-1:0]           pg_cmd_page,
  input  logic                          ifetch_en,
  input  logic [P_OFF_W-1:0]            ifetch_off,
  input  logic                          iload_en,
  input  logic [P_INSTR_W-1:0]          iload_word,
  input  logic                          drd_en,
  input  logic                          dwr_en,
  input  logic [P_OFF_W-1:0]            d_off,
  input  logic [P_DATA_W-1:0]           dwr_byte,
  output logic [P_PAGE_W+P_OFF_W-1:0]   imem_addr,
  output logic                          imem_en,
  output logic [P_INSTR_W-1:0]          instr_word,
  output logic [P_PAGE_W+P_OFF_W-1:0]   dmem_addr,
  output logic                          dmem_rd,
  output logic                          dmem_wr,
  output logic [P_DATA_W-1:0]           drd_byte
);
  localparam int unsigned A_W = P_PAGE_W + P_OFF_W;

  logic                rst_n_sync;
  logic [P_PAGE_W-1:0] page_q [N_SPACE];
  logic [P_PAGE_W-1:0] ipage_q;
  logic [P_PAGE_W-1:0] dpage_q;
  logic [P_INSTR_W-1:0] istore_rd;
  logic [P_DATA_W-1:0]  dstore_rd;

  pmu_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  for (genvar g = 0; g < N_SPACE; g++) begin : g_page
    logic load_this;
    assign load_this = pg_cmd_valid && (pg_cmd_space == 1'(g));
    pmu_page_reg #(.PAGE_W(P_PAGE_W)) u_page (
      .clk     (clk),
      .rst_n   (rst_n_sync),
      .load    (load_this),
      .page_in (pg_cmd_page),
      .page_q  (page_q[g])
    );
  end

  assign ipage_q = page_q[SPACE_INSTR];
  assign dpage_q = page_q[SPACE_DATA];

  assign imem_addr = {ipage_q, ifetch_off};
  assign dmem_addr = {dpage_q, d_off};
  assign imem_en   = ifetch_en | iload_en;
  assign dmem_rd   = drd_en;
  assign dmem_wr   = dwr_en;

  pmu_store #(.WIDTH(P_INSTR_W), .ADDR_W(A_W)) u_istore (
    .clk   (clk),
    .we    (iload_en),
    .addr  (imem_addr),
    .wdata (iload_word),
    .rdata (istore_rd)
  );

  pmu_store #(.WIDTH(P_DATA_W), .ADDR_W(A_W)) u_dstore (
    .clk   (clk),
    .we    (dwr_en),
    .addr  (dmem_addr),
    .wdata (dwr_byte),
    .rdata (dstore_rd)
  );

  always_comb begin
    instr_word = '0;
    if (ifetch_en) instr_word = istore_rd;
  end

  always_comb begin
    drd_byte = '0;
    if (drd_en) drd_byte = dstore_rd;
  end
endmodule

// File: rtl/pmu_checker.sv
`timescale 1ns/1ps
module pmu_checker #(
  parameter int unsigned PW = 3,
  parameter int unsigned OW = 4,
  parameter int unsigned DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pg_cmd_valid,
  input logic          pg_cmd_space,
  input logic [PW-1:0] pg_cmd_page,
  input logic [PW-1:0] ipage_q,
  input logic [PW-1:0] dpage_q,
  input logic          dwr_en,
  input logic          drd_en,
  input logic [OW-1:0] d_off,
  input logic [DW-1:0] dwr_byte,
  input logic [DW-1:0] drd_byte
);
  assert_reset_pages_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (ipage_q == '0 && dpage_q == '0));

  assert_iload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_cmd_valid && !pg_cmd_space) |=> (ipage_q == $past(pg_cmd_page)));

  assert_dload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pg_cmd_valid && pg_cmd_space) |=> (dpage_q == $past(pg_cmd_page)));

  assert_ihold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(pg_cmd_valid && !pg_cmd_space) |=> $stable(ipage_q));

  assert_dhold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(pg_cmd_valid && pg_cmd_space) |=> $stable(dpage_q));

  assert_write_seen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dwr_en && !(pg_cmd_valid && pg_cmd_space)) |=>
      (!(drd_en && d_off == $past(d_off)) || drd_byte == $past(dwr_byte)));

  assert_read_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !drd_en |-> (drd_byte == '0));
endmodule

bind paged_mem_unit pmu_checker #(.PW(P_PAGE_W), .OW(P_OFF_W), .DW(P_DATA_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n_sync),
  .pg_cmd_valid (pg_cmd_valid),
  .pg_cmd_space (pg_cmd_space),
  .pg_cmd_page  (pg_cmd_page),
  .ipage_q      (ipage_q),
  .dpage_q      (dpage_q),
  .dwr_en       (dwr_en),
  .drd_en       (drd_en),
  .d_off        (d_off),
  .dwr_byte     (dwr_byte),
  .drd_byte     (drd_byte)
);

// File: tb/tb_paged_mem_unit.sv
`timescale 1ns/1ps
module tb_paged_mem_unit;
  logic        clk;
  logic        rst_n;
  logic        pg_cmd_valid, pg_cmd_space;
  logic [2:0]  pg_cmd_page;
  logic        ifetch_en, iload_en, drd_en, dwr_en;
  logic [3:0]  ifetch_off, d_off;
  logic [11:0] iload_word;
  logic [7:0]  dwr_byte;
  logic [6:0]  imem_addr, dmem_addr;
  logic        imem_en, dmem_rd, dmem_wr;
  logic [11:0] instr_word;
  logic [7:0]  drd_byte;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int ip = 0, dp = 0;
  int imem_m [128];
  int dmem_m [128];
  int s_iaddr, s_daddr, s_instr, s_dbyte;

  paged_mem_unit dut (
    .clk(clk), .rst_n(rst_n),
    .pg_cmd_valid(pg_cmd_valid), .pg_cmd_space(pg_cmd_space), .pg_cmd_page(pg_cmd_page),
    .ifetch_en(ifetch_en), .ifetch_off(ifetch_off), .iload_en(iload_en), .iload_word(iload_word),
    .drd_en(drd_en), .dwr_en(dwr_en), .d_off(d_off), .dwr_byte(dwr_byte),
    .imem_addr(imem_addr), .imem_en(imem_en), .instr_word(instr_word),
    .dmem_addr(dmem_addr), .dmem_rd(dmem_rd), .dmem_wr(dmem_wr), .drd_byte(drd_byte)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Drive one cycle, compare at the falling edge, advance the model at the rising edge.
  task automatic cyc(input bit pv, input bit pt, input int pp,
                     input bit fe, input int fo, input bit pw, input int pwd,
                     input bit dr, input bit dw, input int dof, input int dwd,
                     input bit model_on);
    int ia, da;
    pg_cmd_valid = pv; pg_cmd_space = pt; pg_cmd_page = 3'(pp);
    ifetch_en = fe; ifetch_off = 4'(fo); iload_en = pw; iload_word = 12'(pwd);
    drd_en = dr; dwr_en = dw; d_off = 4'(dof); dwr_byte = 8'(dwd);
    @(negedge clk);
    ia = ip * 16 + (fo & 15);
    da = dp * 16 + (dof & 15);
    s_iaddr = int'(imem_addr); s_daddr = int'(dmem_addr);
    s_instr = int'(instr_word); s_dbyte = int'(drd_byte);
    chk("R2 imem_addr", s_iaddr, ia);
    chk("R3 dmem_addr", s_daddr, da);
    chk("R10 imem_en", int'(imem_en), int'(fe | pw));
    chk("R10 dmem_rd", int'(dmem_rd), int'(dr));
    chk("R10 dmem_wr", int'(dmem_wr), int'(dw));
    if (model_on) begin
      chk("R8 instr_word", s_instr, fe ? imem_m[ia] : 0);
      chk("R7 drd_byte", s_dbyte, dr ? dmem_m[da] : 0);
    end
    @(posedge clk);
    if (pw) imem_m[ia] = pwd & 12'hFFF;
    if (dw) dmem_m[da] = dwd & 8'hFF;
    if (pv) begin
      if (!pt) ip = pp & 7;
      else     dp = pp & 7;
    end
    #1;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(0,0,0, 0,0, 0,0, 0,0,0,0, 0);
  endtask

  task automatic do_reset();
    rst_n = 0;
    pg_cmd_valid = 1; pg_cmd_space = 0; pg_cmd_page = 3'd5;
    ifetch_en = 0; ifetch_off = 0; iload_en = 0; iload_word = 0;
    drd_en = 0; dwr_en = 0; d_off = 0; dwr_byte = 0;
    repeat (3) @(posedge clk);
    pg_cmd_space = 1;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    pg_cmd_valid = 0;
    ip = 0; dp = 0;
    @(posedge clk); #1;
    idle(3);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: page commands during reset ignored; both pages zero
    cyc(0,0,0, 0,9, 0,0, 0,0,12,0, 0);
    chk("R1 instr page after reset", s_iaddr, 9);
    chk("R1 data page after reset", s_daddr, 12);
    // R5: command cycle still uses the old page
    cyc(1,0,6, 0,1, 0,0, 0,0,2,0, 0);
    chk("R5 same-cycle old ipage", s_iaddr, 1);
    cyc(0,0,0, 0,1, 0,0, 0,0,2,0, 0);
    chk("R5 new ipage next cycle", s_iaddr, 97);
    chk("R4 dpage untouched by target 0", s_daddr, 2);
    cyc(1,1,3, 0,4, 0,0, 0,0,15,0, 0);
    chk("R5 same-cycle old dpage", s_daddr, 15);
    cyc(0,0,0, 0,4, 0,0, 0,0,15,0, 0);
    chk("R4 dpage loaded", s_daddr, 63);
    chk("R4 ipage untouched by target 1", s_iaddr, 100);
    // R11: strobes without commands keep pages
    cyc(0,1,7, 0,0, 0,0, 0,0,0,0, 0);
    cyc(0,0,0, 0,15, 0,0, 0,0,0,0, 0);
    chk("R11 ipage held", s_iaddr, 111);
    chk("R11 dpage held", s_daddr, 48);

    // Fill both stores page by page (R9, R6)
    for (int p = 0; p < 8; p++) begin
      cyc(1,0,p, 0,0, 0,0, 0,0,0,0, 0);
      cyc(1,1,p, 0,0, 0,0, 0,0,0,0, 0);
      for (int o = 0; o < 16; o++)
        cyc(0,0,0, 0,o, 1,(p*16+o)*37+5, 0,1,o,(p*16+o)*11+3, 0);
    end

    // R9: fetch back a loaded word
    cyc(1,0,2, 0,0, 0,0, 0,0,0,0, 1);
    cyc(0,0,0, 1,7, 0,0, 0,0,0,0, 1);
    chk("R9 loaded word fetched", s_instr, (39*37+5) & 12'hFFF);
    cyc(0,0,0, 0,7, 0,0, 0,0,0,0, 1);
    chk("R8 fetch disabled gives zero", s_instr, 0);
    // R6/R7: read during write returns old, then new
    cyc(1,1,4, 0,0, 0,0, 0,0,0,0, 1);
    cyc(0,0,0, 0,0, 0,0, 1,1,5,8'hA5, 1);
    chk("R7 read during write old byte", s_dbyte, (69*11+3) & 8'hFF);
    cyc(0,0,0, 0,0, 0,0, 1,0,5,8'h3C, 1);
    chk("R6 written byte visible", s_dbyte, 8'hA5);
    cyc(0,0,0, 0,0, 0,0, 1,0,5,0, 1);
    chk("R6 no write without strobe", s_dbyte, 8'hA5);
    cyc(0,0,0, 0,0, 0,0, 0,0,5,0, 1);
    chk("R7 read idle zero", s_dbyte, 0);

    // Mixed patterns compared against the model every cycle
    for (int n = 0; n < 1500; n++) begin
      cyc(($urandom % 4) == 0, $urandom % 2, $urandom % 8,
          $urandom % 2, $urandom % 16, ($urandom % 8) == 0, $urandom % 4096,
          $urandom % 2, ($urandom % 3) == 0, $urandom % 16, $urandom % 256, 1);
    end

    // R1: second reset clears pages, stores keep content
    do_reset();
    cyc(0,0,0, 1,3, 0,0, 1,0,8,0, 1);
    chk("R1 ipage zero after second reset", s_iaddr, 3);
    chk("R1 dpage zero after second reset", s_daddr, 8);

    done = 1;
    summary();
    $finish;
  end
endmodule